// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects a single-request host port to an external asynchronous static RAM of 65,536 words of 16 bits. The host offers one access at a time: a direction bit, an address, write data and one enable bit per byte lane. The controller captures the request and runs a fixed sequence of phases on the memory pins. It drives the active-low chip enable, output enable, write enable and the two byte selects, and it drives or releases the bidirectional data bus. Every phase length is a whole number of clock cycles. Each length is the ceiling of a nanosecond figure, set by parameter, divided by the clock period.

A read opens the selected lanes with output enable low. The data bus is sampled on the last access cycle and returned with a one-cycle `rvalid` pulse. An idle turnaround follows with the bus released. A write has three phases. First the data is put on the bus. Then write enable is pulsed low while chip enable and the byte selects stay low. Write enable then rises first, so the write window always closes on that strobe, and the data and remaining strobes are released one cycle later. A request with no lane enabled completes at once and leaves the memory pins untouched.

The phases form a seven-state machine. The states are IDLE, NOP, RD_ACCESS, RD_TURN, WR_SETUP, WR_PULSE and WR_RELEASE. The transitions are as follows:
- IDLE goes to NOP when a request has no lanes. It goes to RD_ACCESS for a read and to WR_SETUP for a write.
- RD_ACCESS goes to RD_TURN when its timer expires, and RD_TURN goes to IDLE the same way.
- WR_SETUP goes to WR_PULSE, WR_PULSE goes to WR_RELEASE when its timer expires, and WR_RELEASE goes to IDLE.
- NOP goes to IDLE.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and in every cycle where `ready` is high, the pins `mem_ce_n`, `mem_oe_n`, `mem_we_n`, `mem_lb_n` and `mem_ub_n` are all high and the controller does not drive `mem_dq`.
- R2: A read keeps `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high. It drives `mem_lb_n` to the inverse of `req_be[0]` and `mem_ub_n` to the inverse of `req_be[1]`. `rvalid` and `done` pulse together for one cycle, RD_CYC cycles after the accepting edge. In `rdata`, the lanes that were not enabled read as zero.
- R3: Lane 0 is bits 7:0 and is enabled by `req_be[0]`. Lane 1 is bits 15:8 and is enabled by `req_be[1]`. A write stores only the enabled lanes and leaves the other lane of that word unchanged.
- R4: `mem_we_n` is low only while `mem_ce_n` is low and at least one byte select is low. Each low pulse lasts at least PWE_CYC cycles, which covers the 8 ns minimum pulse width.
- R5: Write data is driven for at least one cycle before `mem_we_n` falls. When `mem_we_n` rises, chip enable, both byte selects and the data bus are all unchanged, so data setup to the end of the write window is at least 6 ns.
- R6: A request with `req_be` equal to 2'b00 raises `done` one cycle after acceptance, with no `rvalid`. `mem_ce_n` stays high throughout, and the memory contents do not change.
- R7: The controller never drives `mem_dq` while `mem_oe_n` is low, nor in the cycle where `mem_oe_n` has just risen.
- R8: A write raises `done` 2+PWE_CYC cycles after the accepting edge, without `rvalid`.
- R9: `mem_addr` takes the accepted address on the accepting edge and holds it after the host changes `req_addr`. The other request fields are captured on the same edge.
- R10: `mem_oe_n` stays high whenever `mem_we_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request offered; taken on a clock edge where `ready` is high |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 = bits 7:0 |
| ready | output | 1 | Controller idle, request can be taken |
| done | output | 1 | One-cycle completion pulse |
| rvalid | output | 1 | One-cycle read data valid pulse |
| rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | AW | Memory address pins |
| mem_dq | inout | 16 | Memory data bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |

## Verification
The hardest case to reach from the ports is a write that starts right after a read. The memory may still be driving the bus when the controller wants to drive it. The sweep therefore follows every read at once with a write to the same word and holds `req` back by no more than `ready` requires. A bus model watches each lane for unknown values while it is driving that lane. The same model measures the write window in real time, so a strobe released in the wrong order shows up as a setup or pulse-width failure rather than passing silently.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NOP,
        ST_RD_ACCESS,
        ST_RD_TURN,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RELEASE
    } ctl_state_e;

    // whole clock cycles covering a nanosecond figure, never less than one
    function automatic int unsigned span_cycles(int unsigned ns, int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max_of(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
    parameter int unsigned CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    AST_PHASE_NOT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !expired); // R4

endmodule

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
    import sram_lane_pkg::*;
#(
    parameter int unsigned LANES    = 2,
    parameter int unsigned RD_CYC   = 1,
    parameter int unsigned PWE_CYC  = 1,
    parameter int unsigned TURN_CYC = 1,
    parameter int unsigned CW       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_wr,
    input  logic [LANES-1:0] req_be,
    input  logic             expired,
    output ctl_state_e       state_q,
    output ctl_state_e       state_d,
    output logic             accept,
    output logic             load,
    output logic [CW-1:0]    load_val,
    output logic             ready
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    if (req_be == '0) begin
                        state_d = ST_NOP;
                    end else if (req_wr) begin
                        state_d = ST_WR_SETUP;
                    end else begin
                        state_d = ST_RD_ACCESS;
                    end
                end
            end
            ST_NOP:        state_d = ST_IDLE;
            ST_RD_ACCESS:  if (expired) state_d = ST_RD_TURN;
            ST_RD_TURN:    if (expired) state_d = ST_IDLE;
            ST_WR_SETUP:   if (expired) state_d = ST_WR_PULSE;
            ST_WR_PULSE:   if (expired) state_d = ST_WR_RELEASE;
            ST_WR_RELEASE: if (expired) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // phase length of the state being entered, minus one
    always_comb begin
        unique case (state_d)
            ST_RD_ACCESS: load_val = CW'(RD_CYC - 1);
            ST_RD_TURN:   load_val = CW'(TURN_CYC - 1);
            ST_WR_PULSE:  load_val = CW'(PWE_CYC - 1);
            default:      load_val = '0;
        endcase
    end

    assign load   = (state_d != state_q);
    assign ready  = (state_q == ST_IDLE);
    assign accept = ready && req;

    AST_PULSE_EXITS_TO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR_PULSE) |=> (state_q inside {ST_WR_PULSE, ST_WR_RELEASE})); // R5
    AST_READ_ENDS_IN_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_ACCESS) |=> (state_q inside {ST_RD_ACCESS, ST_RD_TURN})); // R7

endmodule

// File: rtl/sram_pin_stage.sv
`timescale 1ns/1ps
module sram_pin_stage
    import sram_lane_pkg::*;
#(
    parameter int unsigned AW    = 16,
    parameter int unsigned LANES = 2,
    localparam int unsigned DW   = LANES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  ctl_state_e       state_d,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [LANES-1:0] req_be,
    output logic [AW-1:0]    addr_q,
    output logic [DW-1:0]    wdata_q,
    output logic [LANES-1:0] lane_en_q,
    output logic             drv_q,
    output logic             ce_n_q,
    output logic             oe_n_q,
    output logic             we_n_q,
    output logic [LANES-1:0] sel_n_q
);

    logic [LANES-1:0] be_eff;
    logic             ce_d, oe_d, we_d, drv_d, lanes_on;
    logic [LANES-1:0] sel_d;

    assign be_eff = accept ? req_be : lane_en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            wdata_q   <= '0;
            lane_en_q <= '0;
        end else if (accept) begin
            addr_q    <= req_addr;
            wdata_q   <= req_wdata;
            lane_en_q <= req_be;
        end
    end

    always_comb begin
        ce_d     = 1'b1;
        oe_d     = 1'b1;
        we_d     = 1'b1;
        drv_d    = 1'b0;
        lanes_on = 1'b0;
        unique case (state_d)
            ST_RD_ACCESS: begin
                ce_d     = 1'b0;
                oe_d     = 1'b0;
                lanes_on = 1'b1;
            end
            ST_WR_SETUP, ST_WR_RELEASE: begin
                ce_d     = 1'b0;
                drv_d    = 1'b1;
                lanes_on = 1'b1;
            end
            ST_WR_PULSE: begin
                ce_d     = 1'b0;
                we_d     = 1'b0;
                drv_d    = 1'b1;
                lanes_on = 1'b1;
            end
            default: begin
                lanes_on = 1'b0;
            end
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane_sel
        assign sel_d[i] = ~(lanes_on & be_eff[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_n_q  <= 1'b1;
            oe_n_q  <= 1'b1;
            we_n_q  <= 1'b1;
            drv_q   <= 1'b0;
            sel_n_q <= '1;
        end else begin
            ce_n_q  <= ce_d;
            oe_n_q  <= oe_d;
            we_n_q  <= we_d;
            drv_q   <= drv_d;
            sel_n_q <= sel_d;
        end
    end

    AST_WE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n_q |-> (!ce_n_q && (sel_n_q != '1))); // R4
    AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n_q |-> oe_n_q); // R10
    AST_NO_DRIVE_WHILE_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n_q |-> !drv_q); // R7

endmodule

// File: rtl/sram_read_return.sv
`timescale 1ns/1ps
module sram_read_return
    import sram_lane_pkg::*;
#(
    parameter int unsigned LANES = 2,
    localparam int unsigned DW   = LANES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_state_e       state_q,
    input  logic             expired,
    input  logic [LANES-1:0] lane_en_q,
    input  logic [DW-1:0]    dq_in,
    output logic [DW-1:0]    rdata,
    output logic             rvalid,
    output logic             done
);

    logic [DW-1:0] lane_mask;

    for (genvar i = 0; i < LANES; i++) begin : g_lane_mask
        assign lane_mask[i*8 +: 8] = {8{lane_en_q[i]}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
            done   <= 1'b0;
        end else begin
            rvalid <= 1'b0;
            done   <= 1'b0;
            if (state_q == ST_RD_ACCESS && expired) begin
                rdata  <= dq_in & lane_mask;
                rvalid <= 1'b1;
                done   <= 1'b1;
            end else if ((state_q == ST_WR_RELEASE && expired) || state_q == ST_NOP) begin
                done <= 1'b1;
            end
        end
    end

    AST_RVALID_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> done); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2

endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int unsigned AW          = 16,
    parameter int unsigned CLK_NS      = 20,
    parameter int unsigned T_ACCESS_NS = 10,
    parameter int unsigned T_WPULSE_NS = 8,
    parameter int unsigned T_DSETUP_NS = 6,
    parameter int unsigned T_ASETUP_NS = 8,
    parameter int unsigned T_OFLOAT_NS = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_wdata,
    input  logic [1:0]    req_be,
    output logic          ready,
    output logic          done,
    output logic          rvalid,
    output logic [15:0]   rdata,
    output logic [AW-1:0] mem_addr,
    inout  wire  [15:0]   mem_dq,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic          mem_lb_n,
    output logic          mem_ub_n
);

    localparam int unsigned LANES    = 2;
    localparam int unsigned DW       = LANES * 8;
    localparam int unsigned RD_CYC   = span_cycles(T_ACCESS_NS, CLK_NS);
    localparam int unsigned PWE_CYC  = max_of(span_cycles(T_WPULSE_NS, CLK_NS),
                                       max_of(span_cycles(T_DSETUP_NS, CLK_NS),
                                              span_cycles(T_ASETUP_NS, CLK_NS)));
    localparam int unsigned TURN_CYC = span_cycles(T_OFLOAT_NS, CLK_NS);
    localparam int unsigned MAXLEN   = max_of(RD_CYC, max_of(PWE_CYC, TURN_CYC));
    localparam int unsigned CW       = $clog2(MAXLEN + 1);
    localparam logic [7:0]  PWE_MIN  = 8'(PWE_CYC);

    ctl_state_e       state_q, state_d;
    logic             accept, load, expired, drv;
    logic [CW-1:0]    load_val;
    logic [DW-1:0]    wdata_q;
    logic [LANES-1:0] lane_en_q, sel_n;
    logic             ce_n, oe_n, we_n;

    sram_phase_timer #(.CW(CW)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    sram_ctrl_fsm #(
        .LANES    (LANES),
        .RD_CYC   (RD_CYC),
        .PWE_CYC  (PWE_CYC),
        .TURN_CYC (TURN_CYC),
        .CW       (CW)
    ) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_wr   (req_wr),
        .req_be   (req_be),
        .expired  (expired),
        .state_q  (state_q),
        .state_d  (state_d),
        .accept   (accept),
        .load     (load),
        .load_val (load_val),
        .ready    (ready)
    );

    sram_pin_stage #(.AW(AW), .LANES(LANES)) i_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .state_d   (state_d),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .addr_q    (mem_addr),
        .wdata_q   (wdata_q),
        .lane_en_q (lane_en_q),
        .drv_q     (drv),
        .ce_n_q    (ce_n),
        .oe_n_q    (oe_n),
        .we_n_q    (we_n),
        .sel_n_q   (sel_n)
    );

    sram_read_return #(.LANES(LANES)) i_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_q   (state_q),
        .expired   (expired),
        .lane_en_q (lane_en_q),
        .dq_in     (mem_dq),
        .rdata     (rdata),
        .rvalid    (rvalid),
        .done      (done)
    );

    assign mem_dq   = drv ? wdata_q : {DW{1'bz}};
    assign mem_ce_n = ce_n;
    assign mem_oe_n = oe_n;
    assign mem_we_n = we_n;
    assign mem_lb_n = sel_n[0];
    assign mem_ub_n = sel_n[1];

    // cycles write enable has been low, kept for the pulse-width check
    logic [7:0] we_low_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_len <= '0;
        end else if (!we_n) begin
            we_low_len <= (we_low_len == 8'hFF) ? we_low_len : we_low_len + 8'd1;
        end else begin
            we_low_len <= '0;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (ce_n && oe_n && we_n && (sel_n == '1) && !drv)); // R1
    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (we_low_len >= PWE_MIN)); // R4
    AST_WE_ENDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (!ce_n && drv && $stable(sel_n))); // R5
    AST_DATA_BEFORE_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> $past(drv)); // R5
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_n) |-> !drv); // R7
    AST_NOP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_be == '0) |=> (ce_n && !rvalid)); // R6

endmodule

// File: tb/test_sram_lane_ctrl.sv
`timescale 1ns/1ps
module test_sram_lane_ctrl;

    localparam int CLK_NS  = 20;
    localparam int PWE_EXP = (8 + CLK_NS - 1) / CLK_NS;   // 8 ns pulse, covers 6/8 ns setups too
    localparam int RD_LAT  = (10 + CLK_NS - 1) / CLK_NS;
    localparam int WR_LAT  = 2 + PWE_EXP;
    localparam int WD_CYC  = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_wr = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        ready, done, rvalid;
    logic [15:0] rdata, mem_addr;
    wire  [15:0] mem_dq;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    always #(CLK_NS/2) clk = ~clk;

    sram_lane_ctrl i_sram_lane_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .ready(ready), .done(done),
        .rvalid(rvalid), .rdata(rdata), .mem_addr(mem_addr), .mem_dq(mem_dq),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    // ---------------- behavioural byte-lane memory ----------------
    logic [15:0] model [0:255];
    wire rd_lo = !mem_ce_n && !mem_oe_n && mem_we_n && !mem_lb_n;
    wire rd_hi = !mem_ce_n && !mem_oe_n && mem_we_n && !mem_ub_n;
    assign mem_dq[7:0]  = rd_lo ? model[mem_addr[7:0]][7:0]  : 8'hzz;
    assign mem_dq[15:8] = rd_hi ? model[mem_addr[7:0]][15:8] : 8'hzz;
    wire win = !mem_ce_n && !mem_we_n && (!mem_lb_n || !mem_ub_n);

    realtime dq_change_t = 0.0;
    realtime win_start_t = 0.0;
    always @(mem_dq) dq_change_t = $realtime;
    always @(posedge win) win_start_t = $realtime;
    always @(negedge win) begin
        chk(($realtime - dq_change_t) >= 6.0, "R5 data setup ns",
            32'(int'($realtime - dq_change_t)), 32'd6);
        chk(($realtime - win_start_t) >= 8.0, "R4 write pulse ns",
            32'(int'($realtime - win_start_t)), 32'd8);
        if (!mem_lb_n) model[mem_addr[7:0]][7:0]  = mem_dq[7:0];
        if (!mem_ub_n) model[mem_addr[7:0]][15:8] = mem_dq[15:8];
    end

    always @(negedge clk) begin
        if (rst_n && (rd_lo || rd_hi)) begin
            chk(!((rd_lo && $isunknown(mem_dq[7:0])) || (rd_hi && $isunknown(mem_dq[15:8]))),
                "R7 bus contention", 32'(mem_dq), 32'(model[mem_addr[7:0]]));
        end
        if (rst_n && !mem_we_n) begin
            chk(mem_oe_n == 1'b1, "R10 oe during write", 32'(mem_oe_n), 32'd1);
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc >= WD_CYC) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired after %0d cycles", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // ---------------- request task ----------------
    task automatic do_req(input bit wr, input logic [15:0] a, input logic [15:0] d,
                          input logic [1:0] b, output int lat, output logic [15:0] rd,
                          output bit rv, output bit ce_low);
        while (!ready) @(negedge clk);
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d; req_be = b;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0; req_wr = ~wr; req_addr = ~a; req_wdata = ~d; req_be = ~b;
        chk(mem_addr == a, "R9 address latched", 32'(mem_addr), 32'(a));
        lat = 0; ce_low = 1'b0; rv = 1'b0;
        while (!done && lat < 50) begin
            if (!mem_ce_n) ce_low = 1'b1;
            @(negedge clk);
            lat++;
        end
        rd = rdata;
        rv = rvalid;
        chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes high at completion",
            {29'd0, mem_ce_n, mem_we_n, mem_oe_n}, 32'd7);
    endtask

    function automatic logic [15:0] addr_of(int k);
        return {8'(k * 43 + 5), 8'(k * 17)};
    endfunction

    function automatic logic [15:0] mask_of(logic [1:0] b);
        return {{8{b[1]}}, {8{b[0]}}};
    endfunction

    logic [15:0] expv [0:15];

    initial begin
        int lat;
        logic [15:0] rd;
        bit rv, cel;
        for (int i = 0; i < 256; i++) model[i] = '0;

        repeat (4) @(negedge clk);
        chk(ready && mem_ce_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n && !done && !rvalid,
            "R1 reset state", {26'd0, ready, mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}, 32'h3F);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready && mem_ce_n && (mem_dq === 16'hzzzz), "R1 idle after reset",
            32'(mem_dq), 32'h0);

        // full-word writes
        for (int k = 0; k < 16; k++) begin
            expv[k] = 16'h3A5C ^ 16'(k * 16'h0F1D);
            do_req(1'b1, addr_of(k), expv[k], 2'b11, lat, rd, rv, cel);
            chk(lat == WR_LAT && !rv, "R8 write latency", 32'(lat), 32'(WR_LAT));
        end
        // full-word reads, each followed at once by a rewrite of the same word
        for (int k = 0; k < 16; k++) begin
            do_req(1'b0, addr_of(k), 16'h0, 2'b11, lat, rd, rv, cel);
            chk(rd == expv[k] && rv, "R2 full read data", 32'(rd), 32'(expv[k]));
            chk(lat == RD_LAT, "R2 read latency", 32'(lat), 32'(RD_LAT));
            do_req(1'b1, addr_of(k), expv[k], 2'b11, lat, rd, rv, cel);
            chk(lat == WR_LAT, "R7 write after read", 32'(lat), 32'(WR_LAT));
        end
        // partial and empty writes
        for (int k = 0; k < 16; k++) begin
            logic [1:0]  b;
            logic [15:0] d, m;
            b = 2'(k % 4);
            d = ~expv[k] + 16'(k);
            m = mask_of(b);
            do_req(1'b1, addr_of(k), d, b, lat, rd, rv, cel);
            if (b == 2'b00) begin
                chk(lat == 1 && !rv && !cel, "R6 empty request",
                    {cel, rv, 30'(lat)}, 32'd1);
            end else begin
                chk(lat == WR_LAT && !rv, "R3 lane write latency", 32'(lat), 32'(WR_LAT));
            end
            expv[k] = (expv[k] & ~m) | (d & m);
        end
        // lane-masked reads
        for (int k = 0; k < 16; k++) begin
            logic [1:0] b;
            b = 2'((k + 1) % 4);
            do_req(1'b0, addr_of(k), 16'h0, b, lat, rd, rv, cel);
            if (b == 2'b00) begin
                chk(lat == 1 && !rv && !cel, "R6 empty read", {cel, rv, 30'(lat)}, 32'd1);
            end else begin
                chk(rd == (expv[k] & mask_of(b)) && rv, "R2 masked read",
                    32'(rd), 32'(expv[k] & mask_of(b)));
            end
        end
        // final full readback proves untouched lanes kept their contents
        for (int k = 0; k < 16; k++) begin
            do_req(1'b0, addr_of(k), 16'h0, 2'b11, lat, rd, rv, cel);
            chk(rd == expv[k], "R3 final contents", 32'(rd), 32'(expv[k]));
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule